// File: doc/BRIEF.md
# Page Buffer Write Sequencer

This block sits between a host's byte-wide write strobes and a behavioural nonvolatile byte array. The host opens a write by holding chip select and write enable low with output enable high. Each qualified strobe deposits one byte into a page-sized staging buffer. The address is taken when the strobe starts and the data when it ends. Bytes may arrive in any order. The load window stays open only while every new byte follows the previous one within an idle timeout.

When the timeout runs out, the block enters a timed internal write. It sweeps the whole page into the array, and every byte that was not loaded in this window becomes FF. A busy flag covers the whole internal write, and strobes arriving during it are dropped. The block also rejects strobes that are too short and refuses all writes for a start-up period after reset. It discards bytes aimed at a page other than the one that opened the window, and it leaves pages alone when they lie in a boot region whose lock input is set. All times are counted in clock cycles. A read port lets the surrounding logic fetch any array byte.

Top module: `pgwr_seq`

## Requirements
- R1: Reset state: busy is 0, last_offset and last_data are 0, and every array byte reads FF.
- R2: During the first PWRON_CYC cycles after reset, strobes load nothing: busy stays 0 and last_offset/last_data keep their reset values.
- R3: A strobe is qualified only in cycles where chip_sel_n = 0, wr_en_n = 0 and out_en_n = 1; with out_en_n = 0 or chip_sel_n = 1 nothing is loaded.
- R4: A qualified strobe lasting fewer than GLITCH_CYC clock cycles is ignored.
- R5: The address is taken in the first qualified cycle of a strobe and the data in its last qualified cycle; last_offset/last_data show the accepted byte two clock edges after the strobe ends.
- R6: Each accepted byte restarts the idle timer; busy rises exactly LOAD_TO_CYC + 2 clock edges after the end of the last accepted strobe.
- R7: Bytes load in any order, and a later byte to the same offset replaces the earlier one.
- R8: A byte whose page (host_addr bits above bit 7) differs from the window's first byte is discarded: last_offset/last_data are unchanged and the array is not written there.
- R9: The commit writes FF to every byte of the page (host_addr bits 7..0 select the byte) not loaded in this window.
- R10: busy stays high for exactly PROG_CYC cycles, and the new page contents are readable when it falls.
- R11: Strobes that end while busy is high are ignored: no new window opens and last_offset/last_data are unchanged.
- R12: With boot_lock_low set, a commit leaves pages whose address bits above BOOT_BITS-1 are all 0 unchanged; with boot_lock_high set, it leaves those where these bits are all 1 unchanged. Other pages commit normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_sel_n | input | 1 | Device select, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output drive request, active low; low inhibits writes |
| host_addr | input | ADDR_W | Byte address: page in upper bits, offset in bits 7..0 |
| host_wdata | input | 8 | Write data |
| boot_lock_low | input | 1 | Lock the lowest boot region against commits |
| boot_lock_high | input | 1 | Lock the highest boot region against commits |
| peek_addr | input | ADDR_W | Array read address |
| busy | output | 1 | Internal write in progress |
| last_offset | output | 8 | Offset of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
A staging-buffer entry that is lost or stale shows up only when the page is read back after busy falls. That is at least LOAD_TO_CYC + PROG_CYC cycles after the byte was loaded, so each commit is followed by a read of all 256 offsets. A broken idle timer or sweep counter shows up at the ports within one window as busy rising or falling on the wrong edge, so both edges are timed to the exact cycle. A wrong page latch or a wrong lock decode shows up in last_offset two edges after a discarded strobe, or in array bytes that should have stayed FF.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    // Byte width of the array and of the staging buffer
    localparam int unsigned BYTE_W = 8;
    // Offset bits inside one page (256 bytes)
    localparam int unsigned OFF_W  = 8;
    localparam int unsigned PAGE_SZ = 1 << OFF_W;
    localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

    typedef enum logic [1:0] {
        ST_PWRON = 2'd0,
        ST_IDLE  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_PROG  = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pgwr_strobe.sv
// Qualifies host strobes, rejects short ones, captures address at start
// and data at end; emits one registered load pulse per good strobe.
module pgwr_strobe
    import pgwr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [BYTE_W-1:0] ld_data
);
    localparam int unsigned WID_W = $clog2(GLITCH_CYC + 1) + 1;

    typedef struct packed {
        logic              act;
        logic [WID_W-1:0]  wid;
        logic [ADDR_W-1:0] cap_addr;
        logic [BYTE_W-1:0] cap_data;
        logic              vld;
        logic [ADDR_W-1:0] out_addr;
        logic [BYTE_W-1:0] out_data;
    } stb_t;

    stb_t stb_d, stb_q;
    logic act_now;

    always_comb begin
        act_now = !chip_sel_n && !wr_en_n && out_en_n;
        stb_d     = stb_q;
        stb_d.vld = 1'b0;
        stb_d.act = act_now;
        if (act_now) begin
            stb_d.cap_data = host_wdata;
            if (!stb_q.act) begin
                stb_d.cap_addr = host_addr;
                stb_d.wid      = WID_W'(1);
            end else if (stb_q.wid != '1) begin
                stb_d.wid = stb_q.wid + WID_W'(1);
            end
        end else if (stb_q.act) begin
            if (stb_q.wid >= WID_W'(GLITCH_CYC)) begin
                stb_d.vld      = 1'b1;
                stb_d.out_addr = stb_q.cap_addr;
                stb_d.out_data = stb_q.cap_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign ld_vld  = stb_q.vld;
    assign ld_addr = stb_q.out_addr;
    assign ld_data = stb_q.out_data;
endmodule

// File: rtl/pgwr_pgbuf.sv
// Page staging buffer: one data byte and one loaded flag per offset.
module pgwr_pgbuf
    import pgwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_hit
);
    logic [BYTE_W-1:0]  store [PAGE_SZ];
    logic [PAGE_SZ-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clr)        seen_d = '0;
        else if (wr_en) seen_d[wr_off] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_off] <= wr_data;
    end

    assign rd_data = store[rd_off];
    assign rd_hit  = seen_q[rd_off];
endmodule

// File: rtl/pgwr_array.sv
// Behavioural nonvolatile array; erased (FF) after reset.
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pgwr_seq.sv
// Page write sequencer top: power-on hold, load window, timed commit sweep.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BOOT_BITS   = 9,
    parameter int unsigned GLITCH_CYC  = 3,
    parameter int unsigned LOAD_TO_CYC = 40,
    parameter int unsigned PWRON_CYC   = 100,
    parameter int unsigned PROG_CYC    = 300   // must be at least PAGE_SZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              boot_lock_low,
    input  logic              boot_lock_high,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic              busy,
    output logic [7:0]        last_offset,
    output logic [7:0]        last_data,
    output logic [7:0]        peek_data
);
    localparam int unsigned PG_W     = ADDR_W - OFF_W;
    localparam int unsigned BOOT_LSB = BOOT_BITS - OFF_W;
    localparam int unsigned LT_W     = $clog2(LOAD_TO_CYC + 1);
    localparam int unsigned PO_W     = $clog2(PWRON_CYC + 1);
    localparam int unsigned PR_W     = $clog2(PROG_CYC + 1);

    typedef struct packed {
        pg_state_e         st;
        logic [PO_W-1:0]   pon;
        logic [LT_W-1:0]   tmr;
        logic [PR_W-1:0]   pcnt;
        logic [PG_W-1:0]   page;
        logic [OFF_W-1:0]  last_off;
        logic [BYTE_W-1:0] last_dat;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [BYTE_W-1:0] ld_data;
    logic [PG_W-1:0]   ld_page;
    logic              buf_wr, buf_clr, buf_hit;
    logic [BYTE_W-1:0] buf_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic              page_locked;

    pgwr_strobe #(
        .ADDR_W    (ADDR_W),
        .GLITCH_CYC(GLITCH_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel_n(chip_sel_n),
        .wr_en_n   (wr_en_n),
        .out_en_n  (out_en_n),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .ld_vld    (ld_vld),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data)
    );

    pgwr_pgbuf u_pgbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_wr),
        .wr_off (ld_addr[OFF_W-1:0]),
        .wr_data(ld_data),
        .clr    (buf_clr),
        .rd_off (seq_q.pcnt[OFF_W-1:0]),
        .rd_data(buf_rdata),
        .rd_hit (buf_hit)
    );

    pgwr_array #(
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(peek_addr),
        .rdata(peek_data)
    );

    assign ld_page = ld_addr[ADDR_W-1:OFF_W];

    // Boot regions are page-granular: the page bits above BOOT_LSB decide.
    always_comb begin
        page_locked = (boot_lock_low  && (seq_q.page[PG_W-1:BOOT_LSB] == '0))
                   || (boot_lock_high && (seq_q.page[PG_W-1:BOOT_LSB] == '1));
    end

    always_comb begin
        seq_d     = seq_q;
        buf_wr    = 1'b0;
        buf_clr   = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = {seq_q.page, seq_q.pcnt[OFF_W-1:0]};
        mem_wdata = buf_hit ? buf_rdata : ERASED;
        unique case (seq_q.st)
            ST_PWRON: begin
                if (seq_q.pon == PO_W'(PWRON_CYC - 1)) seq_d.st = ST_IDLE;
                else seq_d.pon = seq_q.pon + PO_W'(1);
            end
            ST_IDLE: begin
                if (ld_vld) begin
                    buf_wr         = 1'b1;
                    seq_d.page     = ld_page;
                    seq_d.last_off = ld_addr[OFF_W-1:0];
                    seq_d.last_dat = ld_data;
                    seq_d.tmr      = '0;
                    seq_d.st       = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ld_vld && (ld_page == seq_q.page)) begin
                    buf_wr         = 1'b1;
                    seq_d.last_off = ld_addr[OFF_W-1:0];
                    seq_d.last_dat = ld_data;
                    seq_d.tmr      = '0;
                end else if (seq_q.tmr == LT_W'(LOAD_TO_CYC - 1)) begin
                    seq_d.pcnt = '0;
                    seq_d.st   = ST_PROG;
                end else begin
                    seq_d.tmr = seq_q.tmr + LT_W'(1);
                end
            end
            ST_PROG: begin
                mem_we = (seq_q.pcnt < PR_W'(PAGE_SZ)) && !page_locked;
                if (seq_q.pcnt == PR_W'(PROG_CYC - 1)) begin
                    buf_clr  = 1'b1;
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + PR_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_PWRON, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy        = (seq_q.st == ST_PROG);
    assign last_offset = seq_q.last_off;
    assign last_data   = seq_q.last_dat;
endmodule

// File: rtl/pgwr_seq_chk.sv
// Checker bound to the sequencer top.
module pgwr_seq_chk #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BOOT_BITS  = 9,
    parameter int unsigned GLITCH_CYC = 3,
    parameter int unsigned PWRON_CYC  = 100,
    parameter int unsigned PROG_CYC   = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              wr_en_n,
    input logic              out_en_n,
    input logic              boot_lock_low,
    input logic              boot_lock_high,
    input logic              busy,
    input logic [7:0]        last_offset,
    input logic [7:0]        last_data,
    input logic              ld_vld,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    localparam int unsigned AGE_W = $clog2(PWRON_CYC + 1) + 1;
    localparam int unsigned RUN_W = $clog2(PROG_CYC + 1) + 1;

    logic [AGE_W-1:0] age_q;
    logic [RUN_W-1:0] run_q;
    logic [7:0]       act_run_q, act_end_q;
    logic             act;

    assign act = !chip_sel_n && !wr_en_n && out_en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q     <= '0;
            run_q     <= '0;
            act_run_q <= '0;
            act_end_q <= '0;
        end else begin
            if (age_q != '1) age_q <= age_q + AGE_W'(1);
            run_q <= busy ? run_q + RUN_W'(1) : '0;
            if (act) begin
                if (act_run_q != 8'hFF) act_run_q <= act_run_q + 8'd1;
            end else begin
                act_run_q <= 8'd0;
                if (act_run_q != 8'd0) act_end_q <= act_run_q;
            end
        end
    end

    AST_NO_EARLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (age_q >= AGE_W'(PWRON_CYC)));                        // R2
    AST_SHORT_STROBE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |-> (act_end_q >= 8'(GLITCH_CYC)));                     // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(PROG_CYC)));                  // R10
    AST_LAST_FROZEN_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_offset) && $stable(last_data)));        // R11
    AST_LOW_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && boot_lock_low) |-> (mem_waddr[ADDR_W-1:BOOT_BITS] != '0)); // R12
    AST_HIGH_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && boot_lock_high) |-> (mem_waddr[ADDR_W-1:BOOT_BITS] != '1)); // R12
    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);                                              // R10
endmodule

bind pgwr_seq pgwr_seq_chk #(
    .ADDR_W    (ADDR_W),
    .BOOT_BITS (BOOT_BITS),
    .GLITCH_CYC(GLITCH_CYC),
    .PWRON_CYC (PWRON_CYC),
    .PROG_CYC  (PROG_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chip_sel_n    (chip_sel_n),
    .wr_en_n       (wr_en_n),
    .out_en_n      (out_en_n),
    .boot_lock_low (boot_lock_low),
    .boot_lock_high(boot_lock_high),
    .busy          (busy),
    .last_offset   (last_offset),
    .last_data     (last_data),
    .ld_vld        (ld_vld),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr)
);

// File: tb/pgwr_seq_tb.sv
`timescale 1ns/1ps
module pgwr_seq_tb_top;
    localparam int AW   = 12;
    localparam int GL   = 3;
    localparam int LT   = 40;
    localparam int PO   = 100;
    localparam int PR   = 300;
    localparam int NVEC = 8;

    // {addr, data, strobe width, mode(0 good,1 out_en low,2 chip_sel high), accepted}
    localparam logic [26:0] VEC [NVEC] = '{
        {12'h305, 8'hA1, 4'd4, 2'd0, 1'b1},
        {12'h3F0, 8'hB2, 4'd3, 2'd0, 1'b1},
        {12'h300, 8'hC3, 4'd5, 2'd0, 1'b1},
        {12'h305, 8'hD4, 4'd3, 2'd0, 1'b1},
        {12'h710, 8'hEE, 4'd4, 2'd0, 1'b0},
        {12'h311, 8'h99, 4'd2, 2'd0, 1'b0},
        {12'h312, 8'h88, 4'd4, 2'd1, 1'b0},
        {12'h3FF, 8'h5A, 4'd6, 2'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          boot_lock_low = 1'b0, boot_lock_high = 1'b0;
    logic [AW-1:0] peek_addr = '0;
    logic          busy;
    logic [7:0]    last_offset, last_data, peek_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] exp_pg [256];
    logic [7:0] exp_off = 8'h00, exp_dat = 8'h00;

    always #5 clk = ~clk;

    pgwr_seq #(
        .ADDR_W(AW), .BOOT_BITS(9), .GLITCH_CYC(GL),
        .LOAD_TO_CYC(LT), .PWRON_CYC(PO), .PROG_CYC(PR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .boot_lock_low(boot_lock_low), .boot_lock_high(boot_lock_high),
        .peek_addr(peek_addr), .busy(busy), .last_offset(last_offset),
        .last_data(last_data), .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Returns at the negedge where the strobe is released.
    task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d,
                          input int w, input int mode);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        chip_sel_n = (mode == 2);
        wr_en_n    = 1'b0;
        out_en_n   = (mode != 1);
        repeat (w) @(negedge clk);
        chip_sel_n = 1'b1;
        wr_en_n    = 1'b1;
        out_en_n   = 1'b1;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        peek_addr = a;
        #1 v = peek_data;
    endtask

    // Counts edges from strobe release (already 'start' elapsed) to busy rise.
    task automatic rise_check(input int start, input string req);
        int k = start;
        while (!busy && k < LT + 20) begin
            @(negedge clk);
            k++;
        end
        chk(k == LT + 2, req, k, LT + 2);
    endtask

    task automatic len_check(input string req);
        int n = 0;
        while (busy && n < PR + 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == PR, req, n, PR);
    endtask

    initial begin
        logic [7:0] v;
        int bad_ld, bad_ff;
        for (int i = 0; i < 256; i++) exp_pg[i] = 8'hFF;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(last_offset == 8'h00 && last_data == 8'h00, "R1 last", {last_offset, last_data}, 0);
        chk(peek_data == 8'hFF, "R1 array", peek_data, 8'hFF);

        // R2: strobe inside power-on hold
        strobe(12'h207, 8'h42, 5, 0);
        repeat (LT + 10) begin
            @(negedge clk);
            if (busy) break;
        end
        chk(busy == 1'b0, "R2 busy", busy, 0);
        chk(last_offset == 8'h00 && last_data == 8'h00, "R2 last", {last_offset, last_data}, 0);
        repeat (PO) @(negedge clk);
        chk(busy == 1'b0, "R2 no window", busy, 0);
        peek(12'h207, v);
        chk(v == 8'hFF, "R2 array", v, 8'hFF);

        // Table walk: R3, R4, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] e = VEC[i];
            strobe(e[26:15], e[14:7], int'(e[6:3]), int'(e[2:1]));
            if (e[0]) begin
                exp_off = e[22:15];
                exp_dat = e[14:7];
                exp_pg[e[22:15]] = e[14:7];
            end
            repeat (2) @(negedge clk);
            chk(last_offset == exp_off && last_data == exp_dat,
                (e[2:1] != 0) ? "R3 vec" : (e[6:3] < GL) ? "R4 vec" :
                (e[26:23] != 4'h3) ? "R8 vec" : "R7 vec",
                {last_offset, last_data}, {exp_off, exp_dat});
        end
        rise_check(2, "R6 first window");
        // R11: strobe during busy
        strobe(12'h340, 8'h77, 4, 0);
        while (busy) @(negedge clk);
        repeat (LT + 10) begin
            @(negedge clk);
            if (busy) break;
        end
        chk(busy == 1'b0, "R11 no window", busy, 0);
        chk(last_offset == exp_off && last_data == exp_dat, "R11 last",
            {last_offset, last_data}, {exp_off, exp_dat});
        bad_ld = 0;
        bad_ff = 0;
        for (int i = 0; i < 256; i++) begin
            peek({4'h3, 8'(i)}, v);
            if (v !== exp_pg[i]) begin
                if (exp_pg[i] == 8'hFF) bad_ff++;
                else bad_ld++;
            end
        end
        chk(bad_ld == 0, "R7 loaded bytes", bad_ld, 0);
        chk(bad_ff == 0, "R9 filled bytes", bad_ff, 0);
        peek(12'h710, v);
        chk(v == 8'hFF, "R8 other page", v, 8'hFF);

        // R5: address at start, data at end; R6 restart
        @(negedge clk);
        host_addr = 12'h502; host_wdata = 8'h11;
        chip_sel_n = 1'b0; wr_en_n = 1'b0; out_en_n = 1'b1;
        @(negedge clk);
        host_addr = 12'h5AA; host_wdata = 8'h22;
        @(negedge clk);
        host_wdata = 8'h33;
        @(negedge clk);
        chip_sel_n = 1'b1; wr_en_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(last_offset == 8'h02 && last_data == 8'h33, "R5 capture",
            {last_offset, last_data}, 16'h0233);
        repeat (LT - 10) @(negedge clk);
        chk(busy == 1'b0, "R6 still open", busy, 0);
        strobe(12'h503, 8'h44, 3, 0);
        rise_check(0, "R6 restart");
        len_check("R10 busy length");
        peek(12'h502, v);
        chk(v == 8'h33, "R5 array data", v, 8'h33);
        peek(12'h5AA, v);
        chk(v == 8'hFF, "R5 address taken at start", v, 8'hFF);
        peek(12'h503, v);
        chk(v == 8'h44, "R10 array", v, 8'h44);

        // R12: boot locks
        boot_lock_low = 1'b1;
        strobe(12'h010, 8'h12, 4, 0);
        rise_check(0, "R12 low commit");
        len_check("R10 low commit");
        peek(12'h010, v);
        chk(v == 8'hFF, "R12 low locked", v, 8'hFF);
        boot_lock_high = 1'b1;
        strobe(12'h203, 8'h34, 4, 0);
        rise_check(0, "R12 mid commit");
        len_check("R10 mid commit");
        peek(12'h203, v);
        chk(v == 8'h34, "R12 unlocked page", v, 8'h34);
        strobe(12'hE03, 8'h56, 4, 0);
        rise_check(0, "R12 high commit");
        len_check("R10 high commit");
        peek(12'hE03, v);
        chk(v == 8'hFF, "R12 high locked", v, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule